// File: doc/BRIEF.md
# Chopper Current Limit Timer

This block is the digital half of a bridge current regulator. An analog comparator reports that the low-side current has reached the chosen limit. The block then switches the low-side gate off for a programmable off-time and turns it back on afterwards. This keeps the average motor current near the limit, for example while the rotor is stalled. The block also passes the chosen limit code to the comparator references. The over-limit comparator and the shutdown comparator both use it; the shutdown comparator trips 1 A above the limit.

On the first limit hit after arming, the block does not chop. It opens a 10 µs blanking window and keeps the gate on. If the shutdown comparator trips inside that window, the load is taken to be shorted to the supply. A latched short event is then raised and the gate is forced off until a status clear or a reset. Arming happens at reset, on a status clear and whenever the bridge request drops. All durations are counted in clock cycles from a cycles-per-microsecond parameter.

Top module: `chop_limit_ctrl`

## Requirements
- R1: During and right after reset, `ls_gate_en` is 0, `short_vs` is 0 and `ref_code` is 0.
- R2: `ls_gate_en` goes to 1 one cycle after `bridge_on` rises, and goes to 0 one cycle after `bridge_on` falls.
- R3: A limit hit in normal running holds `ls_gate_en` at 0 for exactly N cycles and then turns it back on. N is 24, 43, 62 or 80 times `CYC_PER_US` for `toff_sel` = 2'b00, 2'b01, 2'b10 or 2'b11.
- R4: The first limit hit after arming does not turn the gate off. It opens a blanking window of 10×`CYC_PER_US` cycles, during which `ls_gate_en` stays 1 and `over_lim` is not acted on.
- R5: If `over_sd` is 1 during the blanking window, then from the next cycle `short_vs` is 1 and `ls_gate_en` is 0. Both hold until `stat_clr` or reset, whatever `bridge_on` does.
- R6: `over_sd` outside the blanking window has no effect: `short_vs` stays 0.
- R7: A further `over_lim` pulse during an off-time is ignored. The off-time keeps its original length.
- R8: The off-time length is the one selected by `toff_sel` in the cycle of the hit. Changing `toff_sel` during the off-time does not alter it.
- R9: `ref_code` equals the `lim_sel` value of the previous cycle. Codes 2'b00..2'b11 stand for 4, 5, 6 and 7 A.
- R10: `stat_clr` clears `short_vs`. Both `stat_clr` and a drop of `bridge_on` re-arm blanking, so the next hit again opens a window instead of an off-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| lim_sel | input | 2 | Current limit select |
| toff_sel | input | 2 | Chopper off-time select |
| over_lim | input | 1 | Comparator: current reached the limit |
| over_sd | input | 1 | Comparator: current above the shutdown threshold |
| bridge_on | input | 1 | Bridge drive request |
| stat_clr | input | 1 | Status clear: drops the short event and re-arms blanking |
| ls_gate_en | output | 1 | Low-side gate enable |
| short_vs | output | 1 | Latched short-to-supply event |
| ref_code | output | 2 | Limit code for the limit and shutdown references |

## Verification
Off-time lengths are measured for all four select codes. This separates a wrong duration table from an off-by-one in the counter.

Single hits are compared with hits that get an extra pulse or a change of `toff_sel` while the gate is off. This tells a restartable or re-sampling timer apart from one that latches at the hit.

The shutdown flag is applied once inside the blanking window and also in running and off states. This shows that only the window qualifies it. A short followed by a bridge drop and then a clear shows what latches and what re-arms.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_RUN   = 3'd1,
        ST_BLANK = 3'd2,
        ST_OFF   = 3'd3,
        ST_FAULT = 3'd4
    } chop_state_e;

    localparam int unsigned BLANK_US   = 10;
    localparam int unsigned MAX_OFF_US = 80;

    function automatic int unsigned off_us(input logic [1:0] sel);
        case (sel)
            2'b00:   return 24;
            2'b01:   return 43;
            2'b10:   return 62;
            default: return 80;
        endcase
    endfunction

    function automatic int unsigned off_cycles(input logic [1:0] sel,
                                               input int unsigned cyc_per_us);
        return off_us(sel) * cyc_per_us;
    endfunction

endpackage

// File: rtl/chop_timer.sv
module chop_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/chop_refsel.sv
module chop_refsel #(
    parameter int unsigned CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] sel_in,
    output logic [CODE_W-1:0] code_out
);
    always_ff @(posedge clk) begin
        if (rst) code_out <= '0;
        else     code_out <= sel_in;
    end
endmodule

// File: rtl/chop_fsm.sv
module chop_fsm
    import chop_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 250,
    parameter int unsigned CNT_W      = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       toff_sel,
    input  logic             over_lim,
    input  logic             over_sd,
    input  logic             bridge_on,
    input  logic             stat_clr,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output chop_state_e      state
);
    localparam int unsigned BLANK_CYC = BLANK_US * CYC_PER_US;

    chop_state_e state_d;
    logic        armed_q, armed_d;

    always_comb begin
        state_d  = state;
        armed_d  = armed_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (stat_clr) begin
            state_d = ST_IDLE;
            armed_d = 1'b1;
        end else if (state == ST_FAULT) begin
            state_d = ST_FAULT;
            if (!bridge_on) armed_d = 1'b1;
        end else if (!bridge_on) begin
            state_d = ST_IDLE;
            armed_d = 1'b1;
        end else begin
            case (state)
                ST_IDLE: state_d = ST_RUN;
                ST_RUN: begin
                    if (over_lim) begin
                        tmr_load = 1'b1;
                        if (armed_q) begin
                            state_d = ST_BLANK;
                            armed_d = 1'b0;
                            tmr_val = CNT_W'(BLANK_CYC - 1);
                        end else begin
                            state_d = ST_OFF;
                            tmr_val = CNT_W'(off_cycles(toff_sel, CYC_PER_US) - 1);
                        end
                    end
                end
                ST_BLANK: begin
                    if (over_sd)       state_d = ST_FAULT;
                    else if (tmr_done) state_d = ST_RUN;
                end
                ST_OFF: begin
                    if (tmr_done) state_d = ST_RUN;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            armed_q <= 1'b1;
        end else begin
            state   <= state_d;
            armed_q <= armed_d;
        end
    end
endmodule

// File: rtl/chop_limit_ctrl.sv
module chop_limit_ctrl
    import chop_pkg::*;
#(
    parameter int unsigned CYC_PER_US = 250
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] lim_sel,
    input  logic [1:0] toff_sel,
    input  logic       over_lim,
    input  logic       over_sd,
    input  logic       bridge_on,
    input  logic       stat_clr,
    output logic       ls_gate_en,
    output logic       short_vs,
    output logic [1:0] ref_code
);
    localparam int unsigned MAX_CYC = MAX_OFF_US * CYC_PER_US;
    localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);

    chop_state_e      state;
    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;

    chop_fsm #(.CYC_PER_US(CYC_PER_US), .CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst(rst), .toff_sel(toff_sel), .over_lim(over_lim),
        .over_sd(over_sd), .bridge_on(bridge_on), .stat_clr(stat_clr),
        .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
        .state(state)
    );

    chop_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .done(tmr_done)
    );

    chop_refsel #(.CODE_W(2)) u_ref (
        .clk(clk), .rst(rst), .sel_in(lim_sel), .code_out(ref_code)
    );

    assign ls_gate_en = (state == ST_RUN) || (state == ST_BLANK);
    assign short_vs   = (state == ST_FAULT);
endmodule

// File: rtl/chop_limit_chk.sv
module chop_limit_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] lim_sel,
    input logic       over_sd,
    input logic       bridge_on,
    input logic       stat_clr,
    input logic       ls_gate_en,
    input logic       short_vs,
    input logic [1:0] ref_code
);
    assert_gate_needs_req_R2: assert property (@(posedge clk) disable iff (rst)
        $past(!bridge_on) |-> !ls_gate_en);

    assert_short_kills_gate_R5: assert property (@(posedge clk) disable iff (rst)
        short_vs |-> !ls_gate_en);

    assert_short_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        short_vs && !stat_clr |=> short_vs);

    assert_short_cause_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(short_vs) |-> $past(over_sd));

    assert_ref_follows_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ref_code == $past(lim_sel));
endmodule

bind chop_limit_ctrl chop_limit_chk u_chk (.*);

// File: tb/test_chop_limit_ctrl.sv
module test_chop_limit_ctrl;
    localparam int unsigned CPU = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] lim_sel = 2'b00;
    logic [1:0] toff_sel = 2'b00;
    logic       over_lim = 1'b0, over_sd = 1'b0, bridge_on = 1'b0, stat_clr = 1'b0;
    logic       ls_gate_en, short_vs;
    logic [1:0] ref_code;

    int vectors = 0;
    int miscompares = 0;
    int exp_q[$];
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    chop_limit_ctrl #(.CYC_PER_US(CPU)) i_chop_limit_ctrl (
        .clk(clk), .rst(rst), .lim_sel(lim_sel), .toff_sel(toff_sel),
        .over_lim(over_lim), .over_sd(over_sd), .bridge_on(bridge_on),
        .stat_clr(stat_clr), .ls_gate_en(ls_gate_en), .short_vs(short_vs),
        .ref_code(ref_code)
    );

    function automatic int off_len(input int sel);
        int us[4] = '{24, 43, 62, 80};
        return us[sel] * CPU;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic hit(input int exp_len);
        @(negedge clk);
        over_lim = 1'b1;
        if (exp_len > 0) exp_q.push_back(exp_len);
        @(negedge clk);
        over_lim = 1'b0;
    endtask

    task automatic sd_pulse();
        @(negedge clk);
        over_sd = 1'b1;
        @(negedge clk);
        over_sd = 1'b0;
    endtask

    // monitor: measures each off-time of the low-side gate
    initial begin
        bit prev = 1'b0, active = 1'b0;
        int len = 0;
        forever begin
            @(posedge clk);
            #1;
            if (rst) begin
                prev = 1'b0; active = 1'b0;
            end else begin
                if (!active) begin
                    if (prev && !ls_gate_en && bridge_on && !short_vs) begin
                        active = 1'b1; len = 1;
                    end
                end else if (short_vs || !bridge_on) begin
                    active = 1'b0;
                end else if (!ls_gate_en) begin
                    len++;
                end else begin
                    active = 1'b0;
                    if (exp_q.size() == 0) check("R3 unexpected off-time", len, 0);
                    else check("R3/R7/R8 off-time length", len, exp_q.pop_front());
                end
                prev = ls_gate_en;
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int all_on;
        tick(4);
        check("R1 gate in reset", ls_gate_en, 0);
        check("R1 short in reset", short_vs, 0);
        check("R1 ref in reset", ref_code, 0);
        rst = 1'b0;
        tick(1);
        check("R1 gate after reset", ls_gate_en, 0);
        lim_sel = 2'b10;
        tick(2);
        check("R9 ref code", ref_code, 2);
        lim_sel = 2'b11;
        tick(1);
        check("R9 ref code update", ref_code, 3);

        bridge_on = 1'b1;
        tick(1);
        check("R2 gate on after request", ls_gate_en, 1);

        // first hit: blanking, gate stays on
        hit(0);
        all_on = 1;
        for (int i = 0; i < 35; i++) begin
            if (!ls_gate_en) all_on = 0;
            tick(1);
        end
        check("R4 gate held during blanking", all_on, 1);
        tick(10);

        // shutdown flag outside blanking
        sd_pulse();
        tick(1);
        check("R6 over_sd in run ignored", short_vs, 0);

        toff_sel = 2'b00; hit(off_len(0)); tick(off_len(0) + 10);
        toff_sel = 2'b01; hit(off_len(1)); tick(off_len(1) + 10);
        toff_sel = 2'b10; hit(off_len(2));
        tick(40);
        toff_sel = 2'b11;          // R8: no effect on running off-time
        hit(0);                    // R7: extra hit ignored
        sd_pulse();                // R6: ignored during off-time
        tick(off_len(2));
        check("R6 over_sd in off ignored", short_vs, 0);
        hit(off_len(3)); tick(off_len(3) + 10);
        check("R3 all off-times seen", exp_q.size(), 0);

        // re-arm by dropping request
        bridge_on = 1'b0;
        tick(2);
        check("R2 gate off after request drop", ls_gate_en, 0);
        bridge_on = 1'b1;
        tick(2);
        hit(0);
        tick(2);
        check("R10 re-armed by request drop", ls_gate_en, 1);
        tick(3);
        sd_pulse();
        check("R5 short raised in window", short_vs, 1);
        check("R5 gate off on short", ls_gate_en, 0);
        bridge_on = 1'b0;
        tick(3);
        check("R5 short held over request drop", short_vs, 1);
        bridge_on = 1'b1;
        tick(3);
        check("R5 gate held off", ls_gate_en, 0);
        @(negedge clk); stat_clr = 1'b1;
        @(negedge clk); stat_clr = 1'b0;
        tick(2);
        check("R10 clear drops short", short_vs, 0);
        check("R10 gate back after clear", ls_gate_en, 1);
        hit(0);
        tick(2);
        check("R10 re-armed by clear", ls_gate_en, 1);
        tick(50);
        check("R3 no stray off-time", exp_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule